// File: doc/BRIEF.md
# Dual-Mode Triggered PWM Timer

This block is one timer channel that drives a continuous pulse-width-modulated waveform. It counts a clock-enable tick supplied by an external clock selector. In wide mode the whole reload word sets the high time in ticks, and the period is fixed at the all-ones value of the counter width. In split mode the reload word is divided in two. The lower half is a prescaler: it emits one unit every n+1 ticks. The upper half sets the high time in those units, and the period is the all-ones value of the half width, also in units.

Software programs a mode byte, a reload word and a run bit through a small register port. Modulation starts in one of two ways. A software start begins it as soon as the run bit is set. An external start arms the channel and waits for a chosen edge on a trigger pin. While the channel runs, trigger edges have no effect. A new reload word is adopted at the next period boundary, just before the output rises, so the pulse in progress keeps its width. Each falling edge of the output produces a one-cycle interrupt request.

The controller is a four-state machine. IDLE is halted. ARMED waits for a trigger edge. HIGH drives the output high and LOW drives it low. The named transitions are:
- IDLE→ARMED: the run bit is set in external mode.
- IDLE→HIGH or IDLE→LOW: software start. The target state depends on whether the reload width is nonzero.
- ARMED→HIGH or ARMED→LOW: trigger edge.
- HIGH→LOW: width expired, which is a fall.
- LOW→HIGH or LOW→LOW: wrap at the end of the period.
- HIGH→HIGH or HIGH→LOW: wrap, for full-width or newly zero reloads.
- Any state→IDLE: the run bit is cleared.

Top module: `pwm_timer_ch`

## Requirements
- R1: After reset the output and interrupt are low, the run bit reads 0 and the mode byte reads 0.
- R2: Wide mode (mode bit 5 = 0) with reload m: the output is high for m ticks from the start, and the period is 2^CNT_W−1 ticks.
- R3: Split mode (mode bit 5 = 1) with lower half n and upper half m: the output is high for m·(n+1) ticks, and the period is (2^(CNT_W/2)−1)·(n+1) ticks.
- R4: Only cycles with tick high advance the timing. With a tick every d cycles, all durations scale by d.
- R5: Software start (mode bit 4 = 0): writing 1 to the run bit makes the output high in the very next cycle when m ≠ 0.
- R6: External start (mode bit 4 = 1): the channel stays low until the trigger pin shows the selected edge. Mode bit 3 selects the edge: 0 is falling and 1 is rising. The output is high in the cycle after that edge.
- R7: While running, trigger edges do not change the waveform.
- R8: A data write while halted sets the width of the first pulse. A write while running leaves the current period unchanged, and the new width applies from the next period.
- R9: The interrupt is high for exactly one cycle, in the first low cycle after each fall of the output.
- R10: m = 0 keeps the output low for the whole period. m equal to the full period keeps it high. Neither case raises an interrupt.
- R11: Writing 0 to the run bit drives the output low in the next cycle with no interrupt. An external start then needs a fresh trigger edge.
- R12: If mode bits 2:0 are not 111, setting the run bit produces no output.
- R13: Register selects are 0 for mode, 1 for data and 2 for control (bit 0 is run). A data read in PWM mode returns 0. Mode and run read back as written. Mode writes are ignored while the run bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mode, 1 data, 2 control |
| wr_data | input | CNT_W | Write value; mode uses bits 7:0, control uses bit 0 |
| rd_sel | input | 2 | Read target, same encoding as wr_sel |
| rd_data | output | CNT_W | Combinational read value |
| tick | input | 1 | Count enable from the clock selector |
| trig_in | input | 1 | External start trigger |
| pwm_out | output | 1 | PWM waveform |
| irq | output | 1 | One-cycle request at each output fall |

## Verification
Two situations are hard to reach from the ports. The first is a reload write that lands mid-period. The second is a trigger edge that arrives while the channel is already running. The stimulus task reaches the first by issuing the data write at a chosen sample index inside the loop that also drives the tick pattern. It then measures two consecutive periods and compares each high time against its own width. For the second, the trigger is toggled through a full active edge during the high phase of an externally started pulse, and the high time is checked to still equal the programmed width.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HIGH  = 2'd2,
        ST_LOW   = 2'd3
    } pwm_state_t;

    // register selects
    localparam logic [1:0] SEL_MODE = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    // mode byte fields
    localparam int          MODE_W   = 8;
    localparam logic [2:0]  MODE_PWM = 3'b111;
    localparam int          MB_EDGE  = 3;
    localparam int          MB_EXT   = 4;
    localparam int          MB_HALF  = 5;

endpackage

// File: rtl/pwm_trig_edge.sv
module pwm_trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic rise_sel,
    output logic trig_evt
);
    logic trig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_in;
    end

    // event is visible in the cycle the pin has its new level
    always_comb begin
        if (rise_sel) trig_evt = trig_in & ~trig_q;
        else          trig_evt = ~trig_in & trig_q;
    end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    input  logic          tick,
    input  logic [PW-1:0] n_val,
    output logic          unit
);
    logic [PW-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (load) begin
            pre_q <= n_val;
        end else if (run && tick) begin
            if (pre_q == '0) pre_q <= n_val;
            else             pre_q <= pre_q - 1'b1;
        end
    end

    // one unit per n+1 ticks: issued on the tick that finds zero
    assign unit = run && tick && (pre_q == '0);
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [CNT_W-1:0]    wr_data,
    input  logic [1:0]          rd_sel,
    output logic [CNT_W-1:0]    rd_data,
    output logic [MODE_W-1:0]   mode_q,
    output logic [CNT_W-1:0]    reload_q,
    output logic                start_q
);
    logic is_pwm;
    assign is_pwm = (mode_q[2:0] == MODE_PWM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            reload_q <= '0;
            start_q  <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_MODE: if (!start_q) mode_q <= wr_data[MODE_W-1:0];
                SEL_DATA: reload_q <= wr_data;
                SEL_CTRL: start_q  <= wr_data[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            SEL_MODE: rd_data[MODE_W-1:0] = mode_q;
            SEL_DATA: rd_data = is_pwm ? '0 : reload_q;
            SEL_CTRL: rd_data[0] = start_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/pwm_timer_ch.sv
module pwm_timer_ch
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    input  logic             tick,
    input  logic             trig_in,
    output logic             pwm_out,
    output logic             irq
);
    localparam int         HALF_W    = CNT_W / 2;
    localparam logic [CNT_W-1:0] PER_WIDE_M1 = {{(CNT_W-1){1'b1}}, 1'b0};
    localparam logic [CNT_W-1:0] PER_HALF_M1 = {{(CNT_W-HALF_W){1'b0}}, {(HALF_W-1){1'b1}}, 1'b0};

    // registers
    logic [MODE_W-1:0] mode_r;
    logic [CNT_W-1:0]  reload_r;
    logic              start_r;

    pwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .mode_q   (mode_r),
        .reload_q (reload_r),
        .start_q  (start_r)
    );

    // mode decode
    logic is_pwm, ext_start, half_mode, rise_sel;
    assign is_pwm    = (mode_r[2:0] == MODE_PWM);
    assign ext_start = mode_r[MB_EXT];
    assign half_mode = mode_r[MB_HALF];
    assign rise_sel  = mode_r[MB_EDGE];

    // command decode
    logic ctrl_wr, go_cmd, halt_cmd;
    assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
    assign go_cmd   = ctrl_wr && wr_data[0];
    assign halt_cmd = ctrl_wr && !wr_data[0];

    // width from reload, per mode
    logic [CNT_W-1:0] reload_m;
    logic [CNT_W-1:0] period_m1;
    always_comb begin
        if (half_mode) begin
            reload_m  = '0;
            reload_m[HALF_W-1:0] = reload_r[CNT_W-1:HALF_W];
            period_m1 = PER_HALF_M1;
        end else begin
            reload_m  = reload_r;
            period_m1 = PER_WIDE_M1;
        end
    end

    // state and counters
    pwm_state_t       st, nxt;
    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] width_q;
    logic             irq_q;
    logic             running;
    logic             start_evt, wrap_evt, fall_evt;
    logic             trig_evt, pre_unit, unit;

    assign running = (st == ST_HIGH) || (st == ST_LOW);

    pwm_trig_edge u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .rise_sel (rise_sel),
        .trig_evt (trig_evt)
    );

    pwm_prescaler #(.PW(HALF_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start_evt),
        .run   (running && half_mode),
        .tick  (tick),
        .n_val (reload_r[HALF_W-1:0]),
        .unit  (pre_unit)
    );

    assign unit = half_mode ? pre_unit : tick;

    // next-state logic
    always_comb begin
        nxt       = st;
        start_evt = 1'b0;
        wrap_evt  = 1'b0;
        fall_evt  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (go_cmd && is_pwm) begin
                    if (ext_start) begin
                        nxt = ST_ARMED;
                    end else begin
                        start_evt = 1'b1;
                        nxt = (reload_m != '0) ? ST_HIGH : ST_LOW;
                    end
                end
            end
            ST_ARMED: begin
                if (halt_cmd) begin
                    nxt = ST_IDLE;
                end else if (trig_evt) begin
                    start_evt = 1'b1;
                    nxt = (reload_m != '0) ? ST_HIGH : ST_LOW;
                end
            end
            ST_HIGH: begin
                if (halt_cmd) begin
                    nxt = ST_IDLE;
                end else if (unit) begin
                    if (pos_q == period_m1) begin
                        wrap_evt = 1'b1;
                        if (reload_m == '0) begin
                            nxt      = ST_LOW;
                            fall_evt = 1'b1;
                        end
                    end else if (pos_q == width_q - 1'b1) begin
                        nxt      = ST_LOW;
                        fall_evt = 1'b1;
                    end
                end
            end
            ST_LOW: begin
                if (halt_cmd) begin
                    nxt = ST_IDLE;
                end else if (unit && (pos_q == period_m1)) begin
                    wrap_evt = 1'b1;
                    nxt = (reload_m != '0) ? ST_HIGH : ST_LOW;
                end
            end
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            pos_q   <= '0;
            width_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            st    <= nxt;
            irq_q <= fall_evt;
            if (start_evt || wrap_evt || (nxt == ST_IDLE))
                pos_q <= '0;
            else if (running && unit)
                pos_q <= pos_q + 1'b1;
            // reload moves into the counter just before the next rise
            if (start_evt || wrap_evt)
                width_q <= reload_m;
        end
    end

    // outputs
    always_comb begin
        pwm_out = (st == ST_HIGH);
        irq     = irq_q;
    end
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [CNT_W-1:0]  wr_data,
    input logic [1:0]        rd_sel,
    input logic [CNT_W-1:0]  rd_data,
    input logic              pwm_out,
    input logic              irq,
    input logic [MODE_W-1:0] mode_r,
    input logic              start_r
);
    AST_IRQ_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(pwm_out) && !pwm_out));                              // R9

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);                                                      // R9

    AST_HALT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTRL && !wr_data[0]) |=> (!pwm_out && !irq)); // R11

    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !start_r |-> !pwm_out);                                             // R11

    AST_BAD_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_r[2:0] != MODE_PWM) |-> !pwm_out);                            // R12

    AST_DATA_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == SEL_DATA && mode_r[2:0] == MODE_PWM) |-> (rd_data == '0)); // R13

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        start_r |=> $stable(mode_r));                                       // R13
endmodule

bind pwm_timer_ch pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .pwm_out (pwm_out),
    .irq     (irq),
    .mode_r  (mode_r),
    .start_r (start_r)
);

// File: tb/tb_pwm_timer_ch.sv
`timescale 1ns/1ps
module tb_pwm_timer_ch;
    import pwm_timer_pkg::*;

    localparam int W   = 8;
    localparam int HW  = 4;
    localparam int P16 = 255;
    localparam int P8  = 15;

    logic         clk, rst_n, wr_en, tick, trig_in;
    logic [1:0]   wr_sel, rd_sel;
    logic [W-1:0] wr_data, rd_data;
    logic         pwm_out, irq;

    int n_cmp = 0;
    int n_bad = 0;

    pwm_timer_ch #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .tick(tick), .trig_in(trig_in), .pwm_out(pwm_out), .irq(irq)
    );

    initial begin
        clk = 1'b0;
        forever #4 clk = ~clk;
    end

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [W-1:0] v);
        rd_sel = s;
        #1;
        v = rd_data;
    endtask

    function automatic int falls(input int m, input int per);
        return (m > 0 && m < per) ? 1 : 0;
    endfunction

    // software start, measure nper periods; optional running data write at sample wr_k
    task automatic run(input string tag, input bit half, input logic [W-1:0] d1,
                       input logic [W-1:0] d2, input int wr_k, input int div, input int nper);
        int n, m1, m2, per, ptot, hi1, hi2, irqc, fall1, eirq;
        n    = half ? int'(d1[HW-1:0]) : 0;
        m1   = half ? int'(d1[W-1:HW]) : int'(d1);
        m2   = half ? int'(d2[W-1:HW]) : int'(d2);
        per  = half ? P8 : P16;
        ptot = per * (n + 1) * div;
        tick = 1'b0;
        wr(SEL_MODE, half ? 8'h27 : 8'h07);
        wr(SEL_DATA, d1);                       // halted write loads counter (R8)
        wr(SEL_CTRL, 8'h01);
        hi1 = 0; hi2 = 0; irqc = 0; fall1 = -1;
        for (int k = 0; k <= nper * ptot; k++) begin
            if (k == 0) chk_eq($sformatf("R5 %s first cycle", tag), int'(pwm_out), (m1 != 0) ? 1 : 0);
            if (k < ptot) begin
                if (pwm_out) hi1++;
                else if (fall1 < 0) fall1 = k;
            end else if (k < 2 * ptot) begin
                if (pwm_out) hi2++;
            end
            if (irq) irqc++;
            if (k == ptot)
                chk_eq($sformatf("R8 %s level after wrap", tag), int'(pwm_out), (m2 != 0) ? 1 : 0);
            tick    = ((k + 1) % div == 0);
            wr_en   = (k == wr_k);
            wr_sel  = SEL_DATA;
            wr_data = d2;
            @(negedge clk);
        end
        wr_en = 1'b0;
        tick  = 1'b0;
        chk_eq($sformatf("%s %s%s high time", half ? "R3" : "R2", tag, div > 1 ? " R4" : ""),
               hi1, m1 * (n + 1) * div);
        if (m1 > 0 && m1 < per)
            chk_eq($sformatf("%s %s fall index", half ? "R3" : "R2", tag), fall1, m1 * (n + 1) * div);
        if (nper > 1)
            chk_eq($sformatf("R8 %s second high time", tag), hi2, m2 * (n + 1) * div);
        eirq = falls(m1, per) + ((nper > 1) ? falls(m2, per) : 0);
        chk_eq($sformatf("R9 R10 %s irq count", tag), irqc, eirq);
        wr(SEL_CTRL, 8'h00);
        chk_eq($sformatf("R11 %s halt output", tag), int'(pwm_out), 0);
        chk_eq($sformatf("R11 %s halt irq", tag), int'(irq), 0);
    endtask

    task automatic trig_test(input bit rise);
        logic act, inact;
        int hc;
        act   = rise;
        inact = ~rise;
        tick  = 1'b1;
        trig_in = act;
        wr(SEL_MODE, rise ? 8'h1F : 8'h17);
        wr(SEL_DATA, 8'd3);
        wr(SEL_CTRL, 8'h01);
        trig_in = inact;                        // wrong-direction edge
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            chk_eq($sformatf("R6 edge=%0d wrong edge keeps low", rise), int'(pwm_out), 0);
        end
        trig_in = act;
        @(negedge clk);
        chk_eq($sformatf("R6 edge=%0d active edge starts", rise), int'(pwm_out), 1);
        hc = 1;
        for (int j = 0; j < 9; j++) begin
            if (j == 0) trig_in = inact;
            if (j == 1) trig_in = act;          // full active edge while running
            @(negedge clk);
            if (pwm_out) hc++;
        end
        chk_eq($sformatf("R7 edge=%0d high time with trigger noise", rise), hc, 3);
        wr(SEL_CTRL, 8'h00);
        chk_eq($sformatf("R11 edge=%0d halted low", rise), int'(pwm_out), 0);
        wr(SEL_CTRL, 8'h01);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk_eq($sformatf("R11 edge=%0d re-armed waits", rise), int'(pwm_out), 0);
        end
        trig_in = inact;
        @(negedge clk);
        trig_in = act;
        @(negedge clk);
        chk_eq($sformatf("R11 edge=%0d restart on new edge", rise), int'(pwm_out), 1);
        wr(SEL_CTRL, 8'h00);
        tick = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] v;
        logic [7:0]   mlist [5];
        int           hcnt, icnt;
        mlist[0] = 8'd0; mlist[1] = 8'd1; mlist[2] = 8'd5; mlist[3] = 8'd14; mlist[4] = 8'd15;
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
        tick = 1'b0; trig_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_eq("R1 output after reset", int'(pwm_out), 0);
        chk_eq("R1 irq after reset", int'(irq), 0);
        rd(SEL_CTRL, v); chk_eq("R1 run bit after reset", int'(v), 0);
        rd(SEL_MODE, v); chk_eq("R1 mode after reset", int'(v), 0);

        // R13 register access
        wr(SEL_MODE, 8'h27);
        wr(SEL_DATA, 8'h5A);
        rd(SEL_DATA, v); chk_eq("R13 data read in PWM mode", int'(v), 0);
        rd(SEL_MODE, v); chk_eq("R13 mode readback", int'(v), 'h27);
        wr(SEL_CTRL, 8'h01);
        rd(SEL_CTRL, v); chk_eq("R13 run readback", int'(v), 1);
        wr(SEL_MODE, 8'h07);
        rd(SEL_MODE, v); chk_eq("R13 mode write ignored while running", int'(v), 'h27);
        wr(SEL_CTRL, 8'h00);
        rd(SEL_CTRL, v); chk_eq("R13 run cleared", int'(v), 0);

        // R12 non-PWM mode
        wr(SEL_MODE, 8'h05);
        wr(SEL_DATA, 8'h10);
        tick = 1'b1;
        wr(SEL_CTRL, 8'h01);
        hcnt = 0; icnt = 0;
        for (int j = 0; j < 20; j++) begin
            if (pwm_out) hcnt++;
            if (irq) icnt++;
            @(negedge clk);
        end
        chk_eq("R12 no output outside PWM mode", hcnt, 0);
        chk_eq("R12 no irq outside PWM mode", icnt, 0);
        wr(SEL_CTRL, 8'h00);
        tick = 1'b0;

        // R2 / R10 full sweep of wide-mode width
        for (int m = 0; m < 256; m++)
            run($sformatf("R2 wide m=%0d", m), 1'b0, 8'(m), 8'(m), -1, 1, 1);

        // R3 / R10 split mode: all prescalers, selected widths
        for (int n = 0; n < 16; n++)
            for (int i = 0; i < 5; i++)
                run($sformatf("R3 split n=%0d m=%0d", n, mlist[i]), 1'b1,
                    {mlist[i][3:0], 4'(n)}, {mlist[i][3:0], 4'(n)}, -1, 1, 1);

        // R4 tick gating
        run("R4 wide div3", 1'b0, 8'd10, 8'd10, -1, 3, 1);
        run("R4 wide div2", 1'b0, 8'd200, 8'd200, -1, 2, 1);
        run("R4 split div2", 1'b1, 8'h32, 8'h32, -1, 2, 1);

        // R8 running reload writes
        run("R8 wide grow", 1'b0, 8'd40, 8'd100, 10, 1, 2);
        run("R8 wide to zero", 1'b0, 8'd20, 8'd0, 5, 1, 2);
        run("R8 wide from zero", 1'b0, 8'd0, 8'd7, 3, 1, 2);
        run("R8 split change", 1'b1, 8'h41, 8'h91, 2, 1, 2);

        // R6 / R7 / R11 external triggers
        trig_test(1'b1);
        trig_test(1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule